// File: doc/BRIEF.md
# Conversion Schedule and Settling Sequencer

This block sets the conversion schedule for a slow sigma-delta converter port. While chip-select is low it counts system-clock ticks and divides them into equal update periods. It pulses a conversion-done strobe at the end of each period. A fixed number of cycles before every such strobe it raises a short warning, so the output port can stop a read before its register is rewritten. The default period is 1656 ticks, the crystal divide of 3 × 8 × 69, which gives about 19.79 Hz from a 32.768 kHz clock. The count is a parameter so that simulation can use short periods.

The channel-select and range pins are latched when the block wakes and again whenever either pin changes. A pin change restarts the period and the settling count. The result-valid strobe is held back until enough whole periods have passed since the last wake-up or pin change. Raising chip-select aborts the conversion in progress, enters standby and discards the held result. A stub generator stands in for the filter and produces offset-binary words that depend on the result index, the channel and the range.

Top module: `conv_sequencer`

## Requirements
- R1: While active, `conv_done` pulses for one cycle every `PERIOD_TICKS` cycles. The first pulse is registered `PERIOD_TICKS` clock edges after the wake-up edge, which is the first edge that samples `cs_n` low while in standby.
- R2: `upd_warn` pulses for one cycle exactly `WARN_LEAD` cycles (1 ≤ `WARN_LEAD` < `PERIOD_TICKS`) before each `conv_done` pulse. It never pulses in the same cycle as `conv_done`.
- R3: `data_valid` pulses only together with `conv_done`. After a wake-up or a restart it stays low for the first `SETTLE_N - 1` completed periods. With the default `SETTLE_N` = 2, the first valid word arrives at the end of the second period.
- R4: On the wake-up edge, `lat_ch` and `lat_range` take the levels of `ch_sel` and `range_sel`. They hold while the pins stay unchanged.
- R5: While active, an edge that samples `ch_sel` or `range_sel` different from the latched value has four effects. It relatches both pins and restarts the period count and the settling count from that edge. It also suppresses any `conv_done` that was due at that edge.
- R6: An edge that samples `cs_n` high aborts the block. From the next cycle on, `conv_done`, `upd_warn` and `data_valid` stay low, `result` reads 0, and the result index returns to zero. `lat_ch` and `lat_range` keep their last values.
- R7: `result` changes only in the cycle in which `data_valid` is high. It then carries the stub word for index k, the count of valid words since wake-up, starting at 1. The stub word is the signed value k × `STEP` × gain, negated when `lat_ch` is 1, plus 2^(DATA_W-1). The sum is coded offset binary, so 0x800000 means zero.
- R8: The signed value is clamped to the code range: negative full scale gives 0x000000 and positive full scale gives 0xFFFFFF.
- R9: After reset, all outputs are 0 and the block is in standby.
- R10: `ch_sel` = 0 selects input pair 1 and `ch_sel` = 1 selects pair 2, which the stub negates. `range_sel` = 0 selects gain 16 and `range_sel` = 1 selects gain 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, low wakes and runs the block |
| ch_sel | input | 1 | Input pair select, 0 = pair 1, 1 = pair 2 |
| range_sel | input | 1 | Range select, 0 = gain 16, 1 = gain 1 |
| conv_done | output | 1 | One-cycle strobe at the end of each period |
| upd_warn | output | 1 | One-cycle warning `WARN_LEAD` cycles ahead of `conv_done` |
| data_valid | output | 1 | Strobe marking a settled result |
| result | output | DATA_W | Offset-binary result word |
| lat_ch | output | 1 | Channel latched for the current conversion |
| lat_range | output | 1 | Range latched for the current conversion |

## Verification
The bench drives all four pin combinations through enough periods to walk the stub code from mid-scale to both full-scale clamps. A wrong gain mapping or a missing clamp shows up as a wrapped code. It changes a pin in mid-period and also on exactly the edge where a period would end. A sequencer that let the due strobe through, or that kept its settling count, would report a valid word one period early. It raises chip-select both in mid-period and on a period boundary, then checks that no strobe leaks out and the result is cleared.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef struct packed {
    logic ch;   // 0 = input pair 1, 1 = input pair 2
    logic rng;  // 0 = gain 16, 1 = gain 1
  } pinset_t;

  localparam int unsigned HI_GAIN_SHIFT = 4;

  function automatic int unsigned gain_shift(input logic rng);
    return rng ? 0 : HI_GAIN_SHIFT;
  endfunction

endpackage

// File: rtl/seq_period_timer.sv
module seq_period_timer #(
  parameter int unsigned PERIOD_TICKS = 1656,
  parameter int unsigned WARN_LEAD    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic period_end,
  output logic warn_hit
);
  localparam int unsigned CNT_W = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(PERIOD_TICKS - 1);
  localparam logic [CNT_W-1:0] WARN_AT = CNT_W'(PERIOD_TICKS - 1 - WARN_LEAD);

  logic [CNT_W-1:0] cnt;
  logic             live;

  assign live       = run && !restart;
  assign period_end = live && (cnt == LAST);
  assign warn_hit   = live && (cnt == WARN_AT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!live)             cnt <= '0;
    else if (cnt == LAST)       cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R1
  AST_WARN_APART_FROM_END: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({warn_hit, period_end})); // R2
  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0); // R6

endmodule

// File: rtl/seq_settle_tracker.sv
module seq_settle_tracker #(
  parameter int unsigned SETTLE_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic settled
);
  localparam int unsigned SET_W = $clog2(SETTLE_N + 1);
  localparam logic [SET_W-1:0] FULL = SET_W'(SETTLE_N);
  localparam logic [SET_W-1:0] NEED = SET_W'(SETTLE_N - 1);

  logic [SET_W-1:0] periods;

  // the tick that completes the SETTLE_N-th period is itself valid
  assign settled = (periods >= NEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     periods <= '0;
    else if (clear)                 periods <= '0;
    else if (tick && periods != FULL) periods <= periods + 1'b1;
  end

  AST_SETTLE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    periods <= FULL); // R3
  AST_FRESH_NOT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (SETTLE_N < 2) || !settled); // R3

endmodule

// File: rtl/seq_result_stub.sv
module seq_result_stub
  import conv_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned IDX_W  = 16,
  parameter longint      STEP   = 64'h10_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  pinset_t           sel,
  output logic [DATA_W-1:0] result_q
);
  localparam longint HALF   = 64'sd1 <<< (DATA_W - 1);
  localparam longint POS_FS = HALF - 1;
  localparam longint NEG_FS = -HALF;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_next;

  function automatic logic [DATA_W-1:0] code_of(input logic [IDX_W-1:0] k, input pinset_t s);
    longint mag;
    longint v;
    mag = (longint'(k) * STEP) <<< gain_shift(s.rng);
    v   = s.ch ? -mag : mag;
    if (v > POS_FS) v = POS_FS;
    if (v < NEG_FS) v = NEG_FS;
    v = v + HALF;
    return v[DATA_W-1:0];
  endfunction

  assign idx_next = (idx == IDX_MAX) ? idx : idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      result_q <= '0;
    end else if (clear) begin
      idx      <= '0;
      result_q <= '0;
    end else if (take) begin
      idx      <= idx_next;
      result_q <= code_of(idx_next, sel);
    end
  end

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !take && !clear |=> $stable(result_q)); // R7
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> result_q == '0); // R6

endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int unsigned PERIOD_TICKS = 1656,
  parameter int unsigned WARN_LEAD    = 8,
  parameter int unsigned SETTLE_N     = 2,
  parameter int unsigned DATA_W       = 24,
  parameter int unsigned IDX_W        = 16,
  parameter longint      STEP         = 64'h10_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ch_sel,
  input  logic              range_sel,
  output logic              conv_done,
  output logic              upd_warn,
  output logic              data_valid,
  output logic [DATA_W-1:0] result,
  output logic              lat_ch,
  output logic              lat_range
);
  logic    active;
  pinset_t lat_q;
  pinset_t pins_now;

  // named internal events
  logic wake_ev;
  logic run_ev;
  logic pin_chg_ev;
  logic restart_ev;
  logic period_end;
  logic warn_hit;
  logic settled;
  logic valid_ev;

  assign pins_now   = '{ch: ch_sel, rng: range_sel};
  assign wake_ev    = !active && !cs_n;
  assign run_ev     = active && !cs_n;
  assign pin_chg_ev = run_ev && (pins_now != lat_q);
  assign restart_ev = wake_ev || pin_chg_ev;
  assign valid_ev   = period_end && settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      lat_q  <= '0;
    end else begin
      active <= !cs_n;
      if (restart_ev) lat_q <= pins_now;
    end
  end

  seq_period_timer #(
    .PERIOD_TICKS (PERIOD_TICKS),
    .WARN_LEAD    (WARN_LEAD)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_ev),
    .restart    (pin_chg_ev),
    .period_end (period_end),
    .warn_hit   (warn_hit)
  );

  seq_settle_tracker #(
    .SETTLE_N (SETTLE_N)
  ) settle_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!run_ev || pin_chg_ev),
    .tick    (period_end),
    .settled (settled)
  );

  seq_result_stub #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .STEP   (STEP)
  ) stub_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cs_n),
    .take     (valid_ev),
    .sel      (lat_q),
    .result_q (result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_done  <= 1'b0;
      upd_warn   <= 1'b0;
      data_valid <= 1'b0;
    end else begin
      conv_done  <= period_end;
      upd_warn   <= warn_hit;
      data_valid <= valid_ev;
    end
  end

  assign lat_ch    = lat_q.ch;
  assign lat_range = lat_q.rng;

  AST_VALID_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> conv_done); // R3
  AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !conv_done && !upd_warn && !data_valid && result == '0); // R6
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    run_ev && !pin_chg_ev |=> $stable(lat_q)); // R4
  AST_CHANGE_BLOCKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_chg_ev |=> !conv_done && (lat_q == $past(pins_now))); // R5

endmodule

// File: tb/conv_sequencer_tb.sv
module conv_sequencer_tb_top;
  localparam int unsigned P   = 12;
  localparam int unsigned W   = 3;
  localparam int unsigned SN  = 2;
  localparam int unsigned DW  = 24;
  localparam longint      STP = 64'h10_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic ch_sel = 1'b0;
  logic range_sel = 1'b0;
  logic conv_done, upd_warn, data_valid, lat_ch, lat_range;
  logic [DW-1:0] result;

  conv_sequencer #(
    .PERIOD_TICKS (P),
    .WARN_LEAD    (W),
    .SETTLE_N     (SN),
    .DATA_W       (DW),
    .IDX_W        (16),
    .STEP         (STP)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ch_sel (ch_sel),
    .range_sel (range_sel), .conv_done (conv_done), .upd_warn (upd_warn),
    .data_valid (data_valid), .result (result), .lat_ch (lat_ch),
    .lat_range (lat_range)
  );

  always #2.5 clk = ~clk;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int ec = 0;
  bit finished = 0;

  always @(posedge clk) ec <= ec + 1;

  // bench model state
  bit run_b = 0;
  int t0 = 0;
  int unsigned k = 0;
  logic [DW-1:0] exp_res = '0;
  logic exp_ch = 0, exp_rng = 0;
  string phase = "R9";

  function automatic logic [DW-1:0] ref_code(int unsigned kk, logic c, logic r);
    longint v;
    longint lim;
    lim = longint'(1) << (DW - 1);
    v = longint'(kk) * STP * (r ? 1 : 16);
    if (c) v = -v;
    if (v >= lim) v = lim - 1;
    if (v < -lim) v = -lim;
    v = v + lim;
    return v[DW-1:0];
  endfunction

  task automatic cmp(string tag, longint got, longint expv);
    n_vec++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s (%s) at edge %0d: got %0h expected %0h", tag, phase, ec, got, expv);
    end
  endtask

  task automatic check_edge();
    bit e_done, e_warn, e_valid;
    int d;
    e_done = 0; e_warn = 0; e_valid = 0;
    if (run_b) begin
      d = ec - t0;
      e_done  = (d > 0) && (d % P == 0);
      e_warn  = (d >= int'(P - W)) && ((d + W) % P == 0);
      e_valid = e_done && (d / P >= SN);
      if (e_valid) begin
        k++;
        exp_res = ref_code(k, exp_ch, exp_rng);
      end
    end
    cmp("R1", conv_done, e_done);
    cmp("R2", upd_warn, e_warn);
    cmp("R3", data_valid, e_valid);
    cmp("R4", {lat_ch, lat_range}, {exp_ch, exp_rng});
    if (!run_b) cmp("R6", result, 0);
    else if (exp_res == '0 || exp_res == '1) cmp("R8", result, exp_res);
    else cmp("R7", result, exp_res);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_edge();
    end
  endtask

  // changes are applied right after a check; the next edge samples them
  task automatic wake(logic c, logic r);
    cs_n = 0; ch_sel = c; range_sel = r;
    run_b = 1; t0 = ec + 1; exp_ch = c; exp_rng = r;
  endtask

  task automatic sleep();
    cs_n = 1; run_b = 0; k = 0; exp_res = '0;
  endtask

  task automatic pins(logic c, logic r);
    ch_sel = c; range_sel = r;
    if (run_b && (c != exp_ch || r != exp_rng)) begin
      t0 = ec + 1; exp_ch = c; exp_rng = r;
    end
  endtask

  // advance until the next edge would be a period end
  task automatic to_boundary();
    while (((ec + 1 - t0) % P) != 0) step(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R9";
    step(4);
    // R10 sweep: all channel / range combinations, long enough to clamp (R8)
    for (int cfg = 0; cfg < 4; cfg++) begin
      phase = (cfg == 0) ? "R10 ch0 g16" : (cfg == 1) ? "R10 ch0 g1" :
              (cfg == 2) ? "R10 ch1 g16" : "R10 ch1 g1";
      wake(cfg[1], cfg[0]);
      step(10 * P + 2);
      sleep();
      phase = "R6 idle";
      step(5);
    end
    // R5: pin change mid-period, then on a period boundary
    phase = "R5 mid";
    wake(0, 1);
    step(2 * P + 5);
    pins(1, 1);
    step(3 * P);
    phase = "R5 boundary";
    to_boundary();
    pins(1, 0);
    step(3 * P + 1);
    phase = "R5 no change";
    pins(1, 0);
    step(P);
    // R6: abort mid-period and on a boundary
    phase = "R6 mid";
    step(4);
    sleep();
    step(2 * P);
    phase = "R6 boundary";
    wake(0, 1);
    step(P + 2);
    to_boundary();
    sleep();
    step(2 * P);
    phase = "R4 rewake";
    wake(1, 0);
    step(3 * P + 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule